// File: doc/BRIEF.md
# Debug Bus Access Comparator

This block is a watchpoint comparator for a 16-bit processor bus. Every clock it looks at one bus access and compares it with a stored set of reference values. The access must hit an exact address. It can also be required to have a given direction, a given access width (byte or word), and a data value under a per-bit mask. When every enabled condition holds, the block raises a one-cycle match pulse on the next clock. Sequencing logic, trace capture or breakpoint logic can use that pulse.

Configuration comes in through a single write strobe that loads the whole reference set at once: a global enable, the reference address, the two reference data bytes, the 16-bit data mask, the direction qualifier and the size qualifier. The high reference byte is for the byte at the reference address and travels on bus bits [15:8]. The low reference byte is for the byte one address above and travels on bits [7:0]. The comparator decides on the full address only. A word access that starts one byte below the reference address covers the referenced byte, but it does not match.

Top module: `dbg_access_cmp`

## Requirements
- R1: After reset the match output is 0 and the stored configuration is all zero, including the enable, so no access matches until a configuration write sets the enable.
- R2: A match requires the bus address to equal the reference address exactly. A word access at the reference address minus one never matches.
- R3: Size qualification. With the size-qualify bit at 0, both byte accesses and word accesses may match. With it at 1, only accesses whose byte flag (1 = byte, 0 = word) equals the stored size bit may match.
- R4: Direction qualification. With the direction-qualify bit at 0, the read flag is ignored. With it at 1, a match also needs the bus read flag (1 = read) to equal the stored direction bit.
- R5: For every data bit whose mask bit is 1, the bus data bit must equal the reference bit. The reference high byte is compared against bus bits [15:8] and the reference low byte against bits [7:0]. Unmasked bits are ignored, and the masks 0xFF00, 0x00FF and 0x0F0F each select only their own bits.
- R6: A mask of 0x0000 turns data comparison off, so the match depends on address, size and direction only.
- R7: On a byte access, masked bits in the lane that is not accessed are still compared with whatever the bus drives on that lane. A byte access can therefore match because of the value on bits [7:0], or fail to match because of it.
- R8: The match output is registered. It is 1 in exactly the cycle after a valid access that meets all conditions, and it is 0 after any cycle with the valid strobe low.
- R9: While the stored enable is 0, no match is produced. A configuration write takes effect for accesses sampled on the clock edge after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Loads all cfg_* fields on this edge |
| cfg_en | input | 1 | Global comparator enable |
| cfg_addr | input | 16 | Reference address |
| cfg_dh | input | 8 | Reference byte for the reference address (bus [15:8]) |
| cfg_dl | input | 8 | Reference byte for reference address + 1 (bus [7:0]) |
| cfg_mask | input | 16 | Per-bit data compare mask, 1 = compare |
| cfg_rwe | input | 1 | Direction qualify enable |
| cfg_rw | input | 1 | Required read flag when qualified |
| cfg_sze | input | 1 | Size qualify enable |
| cfg_sz | input | 1 | Required size when qualified (1 = byte) |
| bus_valid | input | 1 | An access is present this cycle |
| bus_addr | input | 16 | Access address |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_data | input | 16 | Bus data, high byte on [15:8] |
| match | output | 1 | Registered one-cycle match pulse |

## Verification
Directed accesses run at the reference address, one byte below it and with the valid strobe low, which separates exact address decoding from overlap decoding. Byte and word accesses go through all three size settings and reads and writes through both direction settings, so each qualifier is shown both to block and to be ignored. Data patterns that flip a single bit inside and outside the masks 0xFFFF, 0xFF00, 0x00FF, 0x0F0F and 0x0000 show lane placement and per-bit masking. Byte accesses with low-lane masks show the unsuppressed lane compare. Randomly mixed configuration writes and accesses, checked against a behavioural model on every clock, then cover the timing of enable changes and configuration updates.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int LANE_W  = 8;
    localparam int N_LANES = DATA_W / LANE_W;

    // stored reference set
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] ref_data;
        logic [DATA_W-1:0] mask;
        logic              rwe;
        logic              rw;
        logic              sze;
        logic              sz;
    } cmp_cfg_t;

    typedef struct packed {
        cmp_cfg_t cfg;
        logic     match;
    } cmp_state_t;

endpackage

// File: rtl/dbg_cmp_qual.sv
// Address, access size and direction qualification.
module dbg_cmp_qual #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ref_addr,
    input  logic [AW-1:0] bus_addr,
    input  logic          rwe,
    input  logic          rw,
    input  logic          sze,
    input  logic          sz,
    input  logic          bus_byte,
    input  logic          bus_rd,
    output logic          qual_ok
);

    logic addr_hit;
    logic size_ok;
    logic dir_ok;

    always_comb begin
        // exact address only; an overlapping word one byte below is not a hit
        addr_hit = (bus_addr == ref_addr);
        size_ok  = !sze || (bus_byte == sz);
        dir_ok   = !rwe || (bus_rd == rw);
        qual_ok  = addr_hit && size_ok && dir_ok;
    end

endmodule

// File: rtl/dbg_cmp_lane.sv
// Masked compare of one byte lane.
module dbg_cmp_lane #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] ref_byte,
    input  logic [LW-1:0] msk_byte,
    input  logic [LW-1:0] bus_byte_val,
    output logic          lane_ok
);

    logic [LW-1:0] bit_ok;

    always_comb begin
        bit_ok  = ~(bus_byte_val ^ ref_byte) | ~msk_byte;
        lane_ok = &bit_ok;
    end

endmodule

// File: rtl/dbg_cmp_data.sv
// Data comparison over all lanes; lanes are compared whatever the access size.
module dbg_cmp_data #(
    parameter int DW = 16,
    parameter int LW = 8
) (
    input  logic [DW-1:0] ref_data,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] bus_data,
    output logic          data_ok
);

    localparam int NL = DW / LW;

    logic [NL-1:0] lane_ok;

    for (genvar gi = 0; gi < NL; gi++) begin : g_lane
        dbg_cmp_lane #(.LW(LW)) u_lane (
            .ref_byte     (ref_data[gi*LW +: LW]),
            .msk_byte     (mask[gi*LW +: LW]),
            .bus_byte_val (bus_data[gi*LW +: LW]),
            .lane_ok      (lane_ok[gi])
        );
    end

    always_comb data_ok = &lane_ok;

endmodule

// File: rtl/dbg_access_cmp.sv
// Watchpoint comparator top: configuration store plus registered match.
module dbg_access_cmp
    import dbg_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LANE_W-1:0] cfg_dh,
    input  logic [LANE_W-1:0] cfg_dl,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic              cfg_rwe,
    input  logic              cfg_rw,
    input  logic              cfg_sze,
    input  logic              cfg_sz,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_byte,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_data,
    output logic              match
);

    cmp_state_t st_d;
    cmp_state_t st_q;
    cmp_cfg_t   cfg_cur;
    logic       qual_ok;
    logic       data_ok;

    assign cfg_cur = st_q.cfg;

    dbg_cmp_qual #(.AW(ADDR_W)) u_qual (
        .ref_addr (cfg_cur.addr),
        .bus_addr (bus_addr),
        .rwe      (cfg_cur.rwe),
        .rw       (cfg_cur.rw),
        .sze      (cfg_cur.sze),
        .sz       (cfg_cur.sz),
        .bus_byte (bus_byte),
        .bus_rd   (bus_rd),
        .qual_ok  (qual_ok)
    );

    dbg_cmp_data #(.DW(DATA_W), .LW(LANE_W)) u_data (
        .ref_data (cfg_cur.ref_data),
        .mask     (cfg_cur.mask),
        .bus_data (bus_data),
        .data_ok  (data_ok)
    );

    always_comb begin
        st_d = st_q;
        // the access is judged against the configuration already stored
        st_d.match = bus_valid && cfg_cur.en && qual_ok && data_ok;
        if (cfg_wr) begin
            st_d.cfg.en       = cfg_en;
            st_d.cfg.addr     = cfg_addr;
            st_d.cfg.ref_data = {cfg_dh, cfg_dl};
            st_d.cfg.mask     = cfg_mask;
            st_d.cfg.rwe      = cfg_rwe;
            st_d.cfg.rw       = cfg_rw;
            st_d.cfg.sze      = cfg_sze;
            st_d.cfg.sz       = cfg_sz;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match = st_q.match;

endmodule

// File: rtl/dbg_cmp_chk.sv
// Temporal checks on the comparator, attached by bind.
module dbg_cmp_chk
    import dbg_cmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              match,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_byte,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_data,
    input cmp_cfg_t          cfg_q
);

    logic              pv;
    logic [ADDR_W-1:0] pa;
    logic              pb;
    logic              pr;
    logic [DATA_W-1:0] pd;
    cmp_cfg_t          pc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= 1'b0;
            pa <= '0;
            pb <= 1'b0;
            pr <= 1'b0;
            pd <= '0;
            pc <= '0;
        end else begin
            pv <= bus_valid;
            pa <= bus_addr;
            pb <= bus_byte;
            pr <= bus_rd;
            pd <= bus_data;
            pc <= cfg_q;
        end
    end

    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> pv); // R8
    AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> pc.en); // R9
    AST_ADDR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (pa == pc.addr)); // R2
    AST_SIZE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (match && pc.sze) |-> (pb == pc.sz)); // R3
    AST_DIR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (match && pc.rwe) |-> (pr == pc.rw)); // R4
    AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (((pd ^ pc.ref_data) & pc.mask) == '0)); // R5

endmodule

bind dbg_access_cmp dbg_cmp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_byte  (bus_byte),
    .bus_rd    (bus_rd),
    .bus_data  (bus_data),
    .cfg_q     (cfg_cur)
);

// File: tb/sim_dbg_access_cmp.sv
module sim_dbg_access_cmp;

    localparam time CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_en = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [7:0]  cfg_dh = '0, cfg_dl = '0;
    logic [15:0] cfg_mask = '0;
    logic        cfg_rwe = 1'b0, cfg_rw = 1'b0, cfg_sze = 1'b0, cfg_sz = 1'b0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_byte = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_data = '0;
    logic        match;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    always #(CLK_PER/2) clk = ~clk;

    dbg_access_cmp u0 (.*);

    // behavioural reference model
    logic        m_en = 1'b0, m_rwe = 1'b0, m_rw = 1'b0, m_sze = 1'b0, m_sz = 1'b0;
    logic [15:0] m_addr = '0, m_ref = '0, m_mask = '0;
    logic        exp_match = 1'b0;

    function automatic logic model_hit();
        if (!bus_valid || !m_en) return 1'b0;
        if (bus_addr != m_addr) return 1'b0;
        if (m_sze && (bus_byte != m_sz)) return 1'b0;
        if (m_rwe && (bus_rd != m_rw)) return 1'b0;
        for (int i = 0; i < 16; i++)
            if (m_mask[i] && (bus_data[i] != m_ref[i])) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_match <= 1'b0;
            {m_en, m_rwe, m_rw, m_sze, m_sz} <= '0;
            m_addr <= '0; m_ref <= '0; m_mask <= '0;
        end else begin
            exp_match <= model_hit();
            if (cfg_wr) begin
                m_en <= cfg_en; m_addr <= cfg_addr; m_ref <= {cfg_dh, cfg_dl};
                m_mask <= cfg_mask; m_rwe <= cfg_rwe; m_rw <= cfg_rw;
                m_sze <= cfg_sze; m_sz <= cfg_sz;
            end
        end
    end

    // per-cycle model comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vecs++;
            if (match !== exp_match) begin
                errs++;
                $display("FAIL %s model: match=%0b expected=%0b", cur_tag, match, exp_match);
            end
        end
    end

    task automatic check(input logic exp, input string tag);
        vecs++;
        if (match !== exp) begin
            errs++;
            $display("FAIL %s directed: match=%0b expected=%0b", tag, match, exp);
        end
    endtask

    task automatic wr_cfg(input logic en, input logic [15:0] a, input logic [7:0] dh,
                          input logic [7:0] dl, input logic [15:0] msk,
                          input logic rwe, input logic rw, input logic sze, input logic sz);
        cfg_wr = 1'b1; cfg_en = en; cfg_addr = a; cfg_dh = dh; cfg_dl = dl;
        cfg_mask = msk; cfg_rwe = rwe; cfg_rw = rw; cfg_sze = sze; cfg_sz = sz;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // drive one access at a falling edge, check the pulse one cycle later
    task automatic acc(input logic v, input logic [15:0] a, input logic byt,
                       input logic rd, input logic [15:0] d,
                       input logic exp, input string tag);
        cur_tag = tag;
        bus_valid = v; bus_addr = a; bus_byte = byt; bus_rd = rd; bus_data = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        check(exp, tag);
    endtask

    localparam logic [15:0] A = 16'h1234;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1'b0, "R1");
        acc(1, 16'h0000, 0, 0, 16'h0000, 0, "R1");   // zeroed config, enable off

        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h0000, 0, 0, 0, 0);
        acc(1, A, 0, 0, 16'h5555, 1, "R2");
        acc(1, A - 16'd1, 0, 0, 16'h5555, 0, "R2");
        acc(1, A + 16'd1, 1, 0, 16'h5555, 0, "R2");
        acc(1, A, 1, 1, 16'h0000, 1, "R6");
        acc(0, A, 0, 0, 16'h0000, 0, "R8");
        check(1'b0, "R8");

        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h0000, 0, 0, 1, 0);
        acc(1, A, 0, 0, 16'h0, 1, "R3");
        acc(1, A, 1, 0, 16'h0, 0, "R3");
        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h0000, 0, 0, 1, 1);
        acc(1, A, 1, 0, 16'h0, 1, "R3");
        acc(1, A, 0, 0, 16'h0, 0, "R3");

        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h0000, 1, 1, 0, 0);
        acc(1, A, 0, 1, 16'h0, 1, "R4");
        acc(1, A, 0, 0, 16'h0, 0, "R4");
        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h0000, 1, 0, 0, 0);
        acc(1, A, 0, 0, 16'h0, 1, "R4");

        wr_cfg(1, A, 8'hAB, 8'hCD, 16'hFFFF, 0, 0, 0, 0);
        acc(1, A, 0, 0, 16'hABCD, 1, "R5");
        acc(1, A, 0, 0, 16'hABCC, 0, "R5");
        acc(1, A, 0, 0, 16'hCDAB, 0, "R5");
        wr_cfg(1, A, 8'hAB, 8'hCD, 16'hFF00, 0, 0, 0, 0);
        acc(1, A, 0, 0, 16'hAB00, 1, "R5");
        acc(1, A, 0, 0, 16'hAA00, 0, "R5");
        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h00FF, 0, 0, 0, 0);
        acc(1, A, 0, 0, 16'h00CD, 1, "R5");
        acc(1, A, 0, 0, 16'hABCF, 0, "R5");
        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h0F0F, 0, 0, 0, 0);
        acc(1, A, 0, 0, 16'h5B5D, 1, "R5");
        acc(1, A, 0, 0, 16'h5A5D, 0, "R5");

        // byte access: low lane still compared
        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h00FF, 0, 0, 1, 1);
        acc(1, A, 1, 0, 16'h00CD, 1, "R7");
        acc(1, A, 1, 0, 16'hABCE, 0, "R7");

        wr_cfg(0, A, 8'hAB, 8'hCD, 16'h0000, 0, 0, 0, 0);
        acc(1, A, 0, 0, 16'h0, 0, "R9");
        wr_cfg(1, A, 8'hAB, 8'hCD, 16'h0000, 0, 0, 0, 0);
        acc(1, A, 0, 0, 16'h0, 1, "R9");

        // random mix against the model
        cur_tag = "R9";
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 8) == 0) begin
                cfg_wr = 1'b1; cfg_en = ($urandom % 4) != 0;
                cfg_addr = A + 16'($urandom % 3);
                cfg_dh = 8'($urandom); cfg_dl = 8'($urandom);
                case ($urandom % 4)
                    0: cfg_mask = 16'h0000;
                    1: cfg_mask = 16'hFF00;
                    2: cfg_mask = 16'h00FF;
                    default: cfg_mask = 16'($urandom) & 16'h0303;
                endcase
                {cfg_rwe, cfg_rw, cfg_sze, cfg_sz} = 4'($urandom);
            end else cfg_wr = 1'b0;
            bus_valid = ($urandom % 5) != 0;
            bus_addr = A + 16'($urandom % 3);
            bus_byte = 1'($urandom); bus_rd = 1'($urandom);
            bus_data = ($urandom % 2) ? {cfg_dh, cfg_dl} ^ (16'($urandom) & 16'h0101)
                                      : 16'($urandom);
            @(negedge clk);
        end
        cfg_wr = 1'b0; bus_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errs++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule